// File: doc/BRIEF.md
# Host DMA Request Handshake Generator

This block drives a DMA request line toward an external DMA controller for a host-interface peripheral. Local firmware starts a request by writing 1 to a trigger bit. The request then stays asserted until the external host accesses the peripheral. The block sees that access on the host chip-select and register-select inputs. These inputs are asynchronous to the peripheral clock, so each passes through a flop synchronizer before any decision uses it.

A setup register holds two bits. A polarity bit picks the asserted level of the request line. A mode bit picks when the request is withdrawn:
- In level mode, the request drops as soon as both inputs are seen low together.
- In release mode, the request drops when chip-select returns high after a qualifying access.

The trigger bit clears on the same clock edge at which the request negates. Its readback therefore doubles as a status flag that does not depend on polarity.

Top module: `hreq_top`

## Requirements
- R1: After reset, busy_o is 0, the setup bits are 0 (level mode, active-low), and dreq_o is 1, the inactive level.
- R2: Writing 1 to the trigger bit while idle sets busy_o at the next clock edge. dreq_o takes the asserted level on that same edge.
- R3: Writing 0 to the trigger bit has no effect. Writing 1 while a request is pending is ignored: it neither restarts nor prolongs the request.
- R4: dreq_o equals the polarity bit while a request is pending and its inverse while idle (polarity 1 = active-high, 0 = active-low).
- R5: In level mode (mode bit 0), a pending request negates at the third rising clock edge after chip-select and register-select are both driven low. It is still asserted at the second.
- R6: In either mode, neither input alone being low negates the request. Register-select low while chip-select is high does not qualify, and chip-select low with register-select high does not qualify either.
- R7: In release mode (mode bit 1), a qualifying access does not negate the request while chip-select stays low. The request negates when chip-select returns high.
- R8: busy_o, the trigger bit readback, falls at the same clock edge at which dreq_o returns to the inactive level.
- R9: In release mode, a chip-select pulse during which register-select stays high does not negate the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Setup register write strobe |
| cfg_mode_i | input | 1 | Negate mode to write: 0 = level, 1 = release |
| cfg_pol_i | input | 1 | Polarity to write: 1 = active-high |
| trig_we_i | input | 1 | Trigger bit write strobe |
| trig_wdata_i | input | 1 | Trigger bit write data (only 1 acts) |
| host_cs_ni | input | 1 | Host chip-select, active low, asynchronous |
| host_rs_ni | input | 1 | Host register-select, active low, asynchronous |
| dreq_o | output | 1 | DMA request line to the external controller |
| busy_o | output | 1 | Trigger bit readback / request pending |
| mode_o | output | 1 | Setup register mode readback |
| pol_o | output | 1 | Setup register polarity readback |

## Verification
The assertions assume that register-select is steady whenever chip-select changes level. Under that assumption, a low register-select seen together with a low chip-select is a real host access. The assertions also assume the setup bits are not rewritten while a request is pending.

The stimulus keeps to both rules. It moves chip-select and register-select together on a falling clock edge and then holds them for several cycles before any release. It writes the setup register only while the block is idle, and it drives every strobe away from the rising edge.

// File: rtl/hreq_pkg.sv
package hreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEEN = 2'd2
  } req_state_e;
endpackage

// File: rtl/hreq_sync.sv
module hreq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hreq_ctrl.sv
module hreq_ctrl
  import hreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_mode_i,
  input  logic cfg_pol_i,
  input  logic trig_we_i,
  input  logic trig_wdata_i,
  input  logic cs_s_ni,
  input  logic rs_s_ni,
  output logic pend_o,
  output logic mode_o,
  output logic pol_o
);
  req_state_e state_q, state_d;
  logic mode_q, pol_q;
  logic trig_set, access;

  assign trig_set = trig_we_i && trig_wdata_i;
  // access qualifies only while chip-select is low
  assign access   = !cs_s_ni && !rs_s_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (cfg_we_i) begin
      mode_q <= cfg_mode_i;
      pol_q  <= cfg_pol_i;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (trig_set) state_d = ST_ARM;
      ST_ARM:  if (access) state_d = mode_q ? ST_SEEN : ST_IDLE;
      ST_SEEN: if (cs_s_ni || (!mode_q && !rs_s_ni)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pend_o = (state_q != ST_IDLE);
  assign mode_o = mode_q;
  assign pol_o  = pol_q;

  assert_trig_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_set && !pend_o) |=> pend_o);

  assert_no_spurious_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && !trig_set) |=> !pend_o);

  assert_level_negate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !mode_q && access) |=> !pend_o);

  assert_need_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !access) |=> pend_o);

  assert_release_negate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pend_o) && $past(mode_q) && $past(state_q == ST_SEEN)) |-> $past(cs_s_ni));

  assert_release_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && mode_q && rs_s_ni) |=> pend_o);
endmodule

// File: rtl/hreq_out.sv
module hreq_out (
  input  logic pend_i,
  input  logic pol_i,
  output logic dreq_o
);
  // idle drives inverse of polarity
  assign dreq_o = pend_i ? pol_i : ~pol_i;
endmodule

// File: rtl/hreq_top.sv
module hreq_top #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic cfg_mode_i,
  input  logic cfg_pol_i,
  input  logic trig_we_i,
  input  logic trig_wdata_i,
  input  logic host_cs_ni,
  input  logic host_rs_ni,
  output logic dreq_o,
  output logic busy_o,
  output logic mode_o,
  output logic pol_o
);
  localparam int unsigned NSIG = 2;

  logic [NSIG-1:0] host_sync;
  logic pend;

  hreq_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({host_cs_ni, host_rs_ni}),
    .sync_o (host_sync)
  );

  hreq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_pol_i   (cfg_pol_i),
    .trig_we_i   (trig_we_i),
    .trig_wdata_i(trig_wdata_i),
    .cs_s_ni     (host_sync[1]),
    .rs_s_ni     (host_sync[0]),
    .pend_o      (pend),
    .mode_o      (mode_o),
    .pol_o       (pol_o)
  );

  hreq_out u_out (
    .pend_i(pend),
    .pol_i (pol_o),
    .dreq_o(dreq_o)
  );

  assign busy_o = pend;

  assert_assert_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $stable(pol_o)) |-> (dreq_o == pol_o));

  assert_clear_with_negate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $stable(pol_o)) |-> (dreq_o != pol_o));
endmodule

// File: tb/hreq_top_tb_top.sv
module hreq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_mode = 0, cfg_pol = 0, trig_we = 0, trig_wd = 0;
  logic cs_n = 1, rs_n = 1;
  logic dreq, busy, mode, pol;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hreq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_pol_i(cfg_pol), .trig_we_i(trig_we), .trig_wdata_i(trig_wd),
    .host_cs_ni(cs_n), .host_rs_ni(rs_n), .dreq_o(dreq), .busy_o(busy),
    .mode_o(mode), .pol_o(pol)
  );

  // {mode, pol, cs_n, rs_n, busy after hold, busy after release}
  localparam int NV = 8;
  localparam logic [5:0] VEC [NV] = '{
    6'b000000,  // R5 level, active-low
    6'b010000,  // R5 level, active-high
    6'b001011,  // R6 rs only
    6'b000111,  // R6 cs only
    6'b100010,  // R7 release, active-low
    6'b110010,  // R7 release, active-high
    6'b100111,  // R9 cs pulse without rs
    6'b111011   // R6 rs only, release mode
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic m, input logic p);
    cfg_we = 1; cfg_mode = m; cfg_pol = p;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic trig(input logic d);
    trig_we = 1; trig_wd = d;
    tick(1);
    trig_we = 0; trig_wd = 0;
  endtask

  task automatic host(input logic c, input logic r, input int n);
    cs_n = c; rs_n = r;
    tick(n);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 busy", busy, 1'b0);
    chk("R1 dreq", dreq, 1'b1);
    chk("R1 mode", mode, 1'b0);
    chk("R1 pol", pol, 1'b0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < NV; i++) begin
      logic m, p, c, r, eh, er;
      {m, p, c, r, eh, er} = VEC[i];
      set_cfg(m, p);
      chk("R4 idle", dreq, ~p);
      trig(1'b1);
      chk("R2 busy", busy, 1'b1);
      chk("R4 asserted", dreq, p);
      host(c, r, 5);
      chk($sformatf("R5/R6/R7 hold v%0d", i), busy, eh);
      chk("R8 hold", dreq, eh ? p : ~p);
      host(1'b1, 1'b1, 5);
      chk($sformatf("R7/R9 release v%0d", i), busy, er);
      chk("R8 release", dreq, er ? p : ~p);
      if (busy) begin
        host(1'b0, 1'b0, 5);
        host(1'b1, 1'b1, 5);
      end
      chk("R8 cleanup", busy, 1'b0);
    end

    // R5: latency to the third edge, R8 same-edge clear
    set_cfg(1'b0, 1'b0);
    trig(1'b1);
    tick(2);
    cs_n = 0; rs_n = 0;
    tick(2);
    chk("R5 second edge", busy, 1'b1);
    chk("R5 second edge dreq", dreq, 1'b0);
    tick(1);
    chk("R5 third edge", busy, 1'b0);
    chk("R8 third edge dreq", dreq, 1'b1);
    host(1'b1, 1'b1, 4);

    // R3: write 0 while idle has no effect
    trig(1'b0);
    tick(2);
    chk("R3 write0 idle", busy, 1'b0);
    chk("R3 write0 dreq", dreq, 1'b1);

    // R3: write 1 during pending release-mode access does not restart
    set_cfg(1'b1, 1'b1);
    trig(1'b1);
    host(1'b0, 1'b0, 5);
    trig(1'b1);
    trig(1'b0);
    chk("R3 rewrite pending", busy, 1'b1);
    host(1'b1, 1'b1, 5);
    chk("R3 no restart", busy, 1'b0);
    chk("R3 no restart dreq", dreq, 1'b0);

    // R3: write 0 while pending does not cancel
    set_cfg(1'b0, 1'b0);
    trig(1'b1);
    trig(1'b0);
    tick(3);
    chk("R3 write0 pending", busy, 1'b1);
    host(1'b0, 1'b0, 5);
    host(1'b1, 1'b1, 4);
    chk("R5 final clear", busy, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule